// File: doc/BRIEF.md
# Clock Divider and Gating Controller

This block turns two synthesized source clocks into the grouped output clocks of a motherboard clock generator. From a host-rate source it drives a bank of host clocks and a bank of PCI clocks at exactly half the host rate. From a 48 MHz bus-rate source it drives a 24 MHz and a 12 MHz peripheral clock. It copies a reference clock to a bank of reference outputs. All sources are sampled by one fast system clock, so every output is a registered level in that single domain.

The host and PCI groups each have an enable that stops the group low and leaves the other groups running. An active-low power-down stops every group. Each enable is captured only while its group clock is low, so an output never emits a shortened high pulse. A two-bit select code picks the requested host rate for the upstream synthesizer. One select code removes the output drive of every group, which is shown on a per-group output-enable vector. A test-mode input replaces all three sources with an external test clock.

Top module: `clkdiv_gate_top`

## Requirements
- R1: While reset is asserted every clock output, every bit of `grp_oe` and `host_rate_66` is 0.
- R2: Each PCI clock runs at exactly half the host clock rate, and a PCI rising edge occurs only in the same cycle as a host rising edge.
- R3: `fd_clk` runs at half and `kb_clk` at a quarter of the bus-source rate, and `kb_clk` changes only in a cycle where `fd_clk` falls.
- R4: Every reference output follows the reference source at the source's rate.
- R5: With `host_en` low, all host clocks settle and stay low while PCI, peripheral and reference clocks keep running.
- R6: With `pci_en` low, all PCI clocks settle and stay low while host, peripheral and reference clocks keep running.
- R7: With `pwr_dn_n` low, every clock output settles and stays low; clocks restart after it returns high.
- R8: An enable change takes effect only while its group clock is low: every output edge coincides with the same edge of the group's ungated clock, and each high pulse keeps its full width.
- R9: `sel` = 2'b11 drives `grp_oe` to all zeros one cycle later; every other code drives it to all ones. Bit 0 is host, bit 1 PCI, bit 2 peripheral, bit 3 reference. Clocks keep toggling underneath.
- R10: `host_rate_66` is 1 one cycle after `sel` = 2'b01 and 0 for codes 2'b00, 2'b10 and 2'b11.
- R11: With `test_mode` high, `test_clk` drives the host, bus and reference paths in place of their sources, so every output runs at its ratio of the test clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | fast system clock that samples all sources |
| rst_n | input | 1 | active-low synchronous reset |
| host_src | input | 1 | host-rate source clock level |
| bus_src | input | 1 | 48 MHz bus-rate source clock level |
| ref_src | input | 1 | reference source clock level |
| test_clk | input | 1 | external test clock level |
| test_mode | input | 1 | 1 routes test_clk into all source paths |
| host_en | input | 1 | host group enable |
| pci_en | input | 1 | PCI group enable |
| pwr_dn_n | input | 1 | active-low global power-down |
| sel | input | 2 | rate / output-drive select code |
| host_clk | output | N_HOST | host clock copies |
| pci_clk | output | N_PCI | PCI clock copies |
| fd_clk | output | 1 | half bus-rate peripheral clock |
| kb_clk | output | 1 | quarter bus-rate peripheral clock |
| ref_clk | output | N_REF | reference clock copies |
| grp_oe | output | 4 | per-group output drive enable |
| host_rate_66 | output | 1 | 1 requests the higher host rate |

## Verification
The bench toggles the host and PCI enables at many phases of the source clock and measures every high pulse; a gate that acted on the enable at once would leave one-cycle slivers that show up as short widths. It counts edges per window in normal and test mode, so a PCI divider fed from the wrong edge, a peripheral counter with a swapped bit, or a test mux that missed one path gives wrong ratios. It checks that PCI rises never happen away from a host rise, and that each group's enable leaves the other groups running, which a shared or crossed enable would break. The select codes are walked so that a decoder that tri-stated on the wrong code or flagged the high rate on 2'b10 miscompares.

// File: rtl/cdg_pkg.sv
package cdg_pkg;

  localparam logic [1:0] SEL_TRI = 2'b11;
  localparam logic [1:0] SEL_66  = 2'b01;

  localparam int NGRP       = 4;
  localparam int GRP_HOST   = 0;
  localparam int GRP_PCI    = 1;
  localparam int GRP_PERIPH = 2;
  localparam int GRP_REF    = 3;

  // Output drive is present for every code except the tri-state code.
  function automatic logic oe_from_sel(input logic [1:0] code);
    return code != SEL_TRI;
  endfunction

  // Only one code asks the synthesizer for the higher host rate.
  function automatic logic rate66_from_sel(input logic [1:0] code);
    return code == SEL_66;
  endfunction

  // Rising-edge detect between a level and its registered copy.
  function automatic logic rise_of(input logic now_lvl, input logic old_lvl);
    return now_lvl & ~old_lvl;
  endfunction

endpackage

// File: rtl/cdg_src_sync.sv
module cdg_src_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/cdg_grp_gate.sv
module cdg_grp_gate #(
  parameter int N = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         lvl,
  input  logic         en,
  output logic [N-1:0] out
);
  logic on_q;
  logic gated;

  // The enable is captured only while the ungated clock is low.
  always_ff @(posedge clk) begin
    if (!rst_n)   on_q <= 1'b0;
    else if (!lvl) on_q <= en;
  end

  assign gated = lvl & on_q;
  assign out   = {N{gated}};

  a_r8_rise_with_src: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gated) |-> $rose(lvl));
  a_r8_fall_with_src: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(gated) |-> $fell(lvl));
endmodule

// File: rtl/cdg_bus_div.sv
module cdg_bus_div #(
  parameter int DIV_BITS = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bus_lvl,
  output logic [DIV_BITS-1:0] taps
);
  import cdg_pkg::*;

  logic                bus_q;
  logic                bus_rise;
  logic [DIV_BITS-1:0] cnt;

  assign bus_rise = rise_of(bus_lvl, bus_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bus_q <= 1'b0;
      cnt   <= '0;
    end else begin
      bus_q <= bus_lvl;
      if (bus_rise) cnt <= cnt + 1'b1;
    end
  end

  assign taps = cnt;

  a_r3_count_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cnt) |-> $past(bus_rise));
endmodule

// File: rtl/clkdiv_gate_top.sv
module clkdiv_gate_top #(
  parameter int N_HOST      = 4,
  parameter int N_PCI       = 8,
  parameter int N_REF       = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_src,
  input  logic              bus_src,
  input  logic              ref_src,
  input  logic              test_clk,
  input  logic              test_mode,
  input  logic              host_en,
  input  logic              pci_en,
  input  logic              pwr_dn_n,
  input  logic [1:0]        sel,
  output logic [N_HOST-1:0] host_clk,
  output logic [N_PCI-1:0]  pci_clk,
  output logic              fd_clk,
  output logic              kb_clk,
  output logic [N_REF-1:0]  ref_clk,
  output logic [3:0]        grp_oe,
  output logic              host_rate_66
);
  import cdg_pkg::*;

  localparam int DIV_BITS = 2;

  // Source selection: test mode replaces every synthesized source.
  logic host_pick, bus_pick, ref_pick;
  assign host_pick = test_mode ? test_clk : host_src;
  assign bus_pick  = test_mode ? test_clk : bus_src;
  assign ref_pick  = test_mode ? test_clk : ref_src;

  logic host_lvl, bus_lvl, ref_lvl;

  cdg_src_sync #(.STAGES(SYNC_STAGES)) u_sync_host (
    .clk(clk), .rst_n(rst_n), .d(host_pick), .q(host_lvl));
  cdg_src_sync #(.STAGES(SYNC_STAGES)) u_sync_bus (
    .clk(clk), .rst_n(rst_n), .d(bus_pick), .q(bus_lvl));
  cdg_src_sync #(.STAGES(SYNC_STAGES)) u_sync_ref (
    .clk(clk), .rst_n(rst_n), .d(ref_pick), .q(ref_lvl));

  // Host level and PCI divider share one register stage so that a PCI
  // rise lands in the same cycle as the host rise that caused it.
  logic host_q, pci_q, host_rise;
  assign host_rise = rise_of(host_lvl, host_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      host_q <= 1'b0;
      pci_q  <= 1'b0;
    end else begin
      host_q <= host_lvl;
      if (host_rise) pci_q <= ~pci_q;
    end
  end

  a_r2_pci_on_host_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pci_q) |-> $rose(host_q));

  // Peripheral dividers from the bus source.
  logic [DIV_BITS-1:0] taps;
  logic fd_lvl, kb_lvl;

  cdg_bus_div #(.DIV_BITS(DIV_BITS)) u_bus_div (
    .clk(clk), .rst_n(rst_n), .bus_lvl(bus_lvl), .taps(taps));

  assign fd_lvl = taps[0];
  assign kb_lvl = taps[1];

  a_r3_kb_on_fd_fall: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(kb_lvl) |-> $fell(fd_lvl));

  // Group gates.
  logic host_on_req, pci_on_req;
  assign host_on_req = host_en & pwr_dn_n;
  assign pci_on_req  = pci_en & pwr_dn_n;

  cdg_grp_gate #(.N(N_HOST)) u_gate_host (
    .clk(clk), .rst_n(rst_n), .lvl(host_q), .en(host_on_req), .out(host_clk));
  cdg_grp_gate #(.N(N_PCI)) u_gate_pci (
    .clk(clk), .rst_n(rst_n), .lvl(pci_q), .en(pci_on_req), .out(pci_clk));
  cdg_grp_gate #(.N(1)) u_gate_fd (
    .clk(clk), .rst_n(rst_n), .lvl(fd_lvl), .en(pwr_dn_n), .out(fd_clk));
  cdg_grp_gate #(.N(1)) u_gate_kb (
    .clk(clk), .rst_n(rst_n), .lvl(kb_lvl), .en(pwr_dn_n), .out(kb_clk));
  cdg_grp_gate #(.N(N_REF)) u_gate_ref (
    .clk(clk), .rst_n(rst_n), .lvl(ref_lvl), .en(pwr_dn_n), .out(ref_clk));

  // Select decode: per-group output drive and rate request.
  logic [NGRP-1:0] oe_q;
  logic            rate_q;
  logic            oe_next;
  assign oe_next = oe_from_sel(sel);

  generate
    for (genvar g = 0; g < NGRP; g++) begin : g_oe
      always_ff @(posedge clk) begin
        if (!rst_n) oe_q[g] <= 1'b0;
        else        oe_q[g] <= oe_next;
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) rate_q <= 1'b0;
    else        rate_q <= rate66_from_sel(sel);
  end

  assign grp_oe       = oe_q;
  assign host_rate_66 = rate_q;

  a_r9_tristate_code: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == SEL_TRI) |=> (grp_oe == '0));
  a_r10_rate_only_66: assert property (@(posedge clk) disable iff (!rst_n)
    (sel != SEL_66) |=> !host_rate_66);
endmodule

// File: tb/clkdiv_gate_top_tb.sv
module clkdiv_gate_top_tb_top;
  localparam int NH = 4;
  localparam int NP = 8;
  localparam int NR = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic host_src = 1'b0, bus_src = 1'b0, ref_src = 1'b0, test_clk = 1'b0;
  logic test_mode = 1'b0, host_en = 1'b1, pci_en = 1'b1, pwr_dn_n = 1'b1;
  logic [1:0] sel = 2'b00;
  logic [NH-1:0] host_clk;
  logic [NP-1:0] pci_clk;
  logic fd_clk, kb_clk;
  logic [NR-1:0] ref_clk;
  logic [3:0] grp_oe;
  logic host_rate_66;

  always #10 clk = ~clk;

  clkdiv_gate_top #(.N_HOST(NH), .N_PCI(NP), .N_REF(NR)) dut_i (
    .clk(clk), .rst_n(rst_n), .host_src(host_src), .bus_src(bus_src),
    .ref_src(ref_src), .test_clk(test_clk), .test_mode(test_mode),
    .host_en(host_en), .pci_en(pci_en), .pwr_dn_n(pwr_dn_n), .sel(sel),
    .host_clk(host_clk), .pci_clk(pci_clk), .fd_clk(fd_clk), .kb_clk(kb_clk),
    .ref_clk(ref_clk), .grp_oe(grp_oe), .host_rate_66(host_rate_66));

  // Source half-periods in system cycles.
  localparam int HH = 2, BH = 1, RH = 4, TH = 3;
  int cyc = 0;
  always @(negedge clk) begin
    cyc      <= cyc + 1;
    host_src <= (cyc % (2*HH)) < HH;
    bus_src  <= (cyc % (2*BH)) < BH;
    ref_src  <= (cyc % (2*RH)) < RH;
    test_clk <= (cyc % (2*TH)) < TH;
  end

  int n_chk = 0, n_bad = 0;
  int r_h, r_p, r_f, r_k, r_r;
  int w_h, w_p, bad_wh, bad_wp, bad_align, bad_copy;
  int exp_wh = HH, exp_wp = 2*HH;
  bit runt_chk = 0;
  logic p_h = 0, p_p = 0, p_f = 0, p_k = 0, p_r = 0;

  always @(negedge clk) begin
    if (host_clk[0] && !p_h) r_h++;
    if (pci_clk[0] && !p_p) r_p++;
    if (fd_clk && !p_f) r_f++;
    if (kb_clk && !p_k) r_k++;
    if (ref_clk[0] && !p_r) r_r++;
    if (pci_clk[0] && !p_p && !(host_clk[0] && !p_h)) bad_align++;
    if (host_clk != {NH{host_clk[0]}} || pci_clk != {NP{pci_clk[0]}} ||
        ref_clk != {NR{ref_clk[0]}}) bad_copy++;
    if (host_clk[0]) w_h++;
    if (pci_clk[0]) w_p++;
    if (p_h && !host_clk[0]) begin
      if (runt_chk && w_h != exp_wh) bad_wh++;
      w_h = 0;
    end
    if (p_p && !pci_clk[0]) begin
      if (runt_chk && w_p != exp_wp) bad_wp++;
      w_p = 0;
    end
    p_h = host_clk[0]; p_p = pci_clk[0]; p_f = fd_clk; p_k = kb_clk; p_r = ref_clk[0];
  end

  task automatic chk(input string req, input string what, input int act,
                     input int lo, input int hi);
    n_chk++;
    if (act < lo || act > hi) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d..%0d", req, what, act, lo, hi);
    end
  endtask

  task automatic measure(input int cycles);
    @(posedge clk);
    r_h = 0; r_p = 0; r_f = 0; r_k = 0; r_r = 0;
    bad_align = 0; bad_copy = 0;
    repeat (cycles) @(posedge clk);
  endtask

  task automatic t_reset;
    repeat (3) @(negedge clk);
    chk("R1", "host_clk", int'(host_clk), 0, 0);
    chk("R1", "pci_clk", int'(pci_clk), 0, 0);
    chk("R1", "fd/kb/ref", int'({fd_clk, kb_clk, ref_clk}), 0, 0);
    chk("R1", "grp_oe", int'(grp_oe), 0, 0);
    chk("R1", "host_rate_66", int'(host_rate_66), 0, 0);
  endtask

  task automatic t_basic;
    runt_chk = 1;
    measure(400);
    chk("R2", "host rises", r_h, 99, 101);
    chk("R2", "pci rises", r_p, 49, 51);
    chk("R2", "pci rise off host rise", bad_align, 0, 0);
    chk("R3", "fd rises", r_f, 99, 101);
    chk("R3", "kb rises", r_k, 49, 51);
    chk("R4", "ref rises", r_r, 49, 51);
    chk("R4", "copies differ", bad_copy, 0, 0);
    chk("R9", "grp_oe normal", int'(grp_oe), 15, 15);
  endtask

  task automatic t_host_en;
    @(negedge clk) host_en = 1'b0;
    repeat (20) @(negedge clk);
    measure(200);
    chk("R5", "host rises while off", r_h, 0, 0);
    chk("R5", "host level", int'(host_clk), 0, 0);
    chk("R5", "pci keeps running", r_p, 24, 26);
    chk("R5", "fd keeps running", r_f, 49, 51);
    chk("R5", "ref keeps running", r_r, 24, 26);
    @(negedge clk) host_en = 1'b1;
    repeat (20) @(negedge clk);
    measure(200);
    chk("R5", "host restarts", r_h, 49, 51);
  endtask

  task automatic t_pci_en;
    @(negedge clk) pci_en = 1'b0;
    repeat (20) @(negedge clk);
    measure(200);
    chk("R6", "pci rises while off", r_p, 0, 0);
    chk("R6", "pci level", int'(pci_clk), 0, 0);
    chk("R6", "host keeps running", r_h, 49, 51);
    chk("R6", "kb keeps running", r_k, 24, 26);
    @(negedge clk) pci_en = 1'b1;
    repeat (20) @(negedge clk);
    measure(200);
    chk("R6", "pci restarts", r_p, 24, 26);
  endtask

  task automatic t_runt;
    bad_wh = 0; bad_wp = 0;
    for (int k = 0; k < 24; k++) begin
      repeat (k % 7 + 1) @(negedge clk);
      host_en = ~host_en;
      if (k % 3 == 0) pci_en = ~pci_en;
    end
    @(negedge clk) begin host_en = 1'b1; pci_en = 1'b1; end
    repeat (30) @(negedge clk);
    chk("R8", "short host pulses", bad_wh, 0, 0);
    chk("R8", "short pci pulses", bad_wp, 0, 0);
  endtask

  task automatic t_sel;
    @(negedge clk) sel = 2'b01;
    repeat (2) @(negedge clk);
    chk("R10", "rate for 01", int'(host_rate_66), 1, 1);
    chk("R9", "oe for 01", int'(grp_oe), 15, 15);
    @(negedge clk) sel = 2'b11;
    repeat (2) @(negedge clk);
    chk("R9", "oe for 11", int'(grp_oe), 0, 0);
    chk("R10", "rate for 11", int'(host_rate_66), 0, 0);
    measure(200);
    chk("R9", "host runs under tristate", r_h, 49, 51);
    @(negedge clk) sel = 2'b10;
    repeat (2) @(negedge clk);
    chk("R10", "rate for 10", int'(host_rate_66), 0, 0);
    chk("R9", "oe for 10", int'(grp_oe), 15, 15);
    @(negedge clk) sel = 2'b00;
    repeat (2) @(negedge clk);
    chk("R10", "rate for 00", int'(host_rate_66), 0, 0);
  endtask

  task automatic t_pwr;
    @(negedge clk) pwr_dn_n = 1'b0;
    repeat (20) @(negedge clk);
    measure(200);
    chk("R7", "rises while down", r_h + r_p + r_f + r_k + r_r, 0, 0);
    chk("R7", "levels while down",
        int'(|{host_clk, pci_clk, fd_clk, kb_clk, ref_clk}), 0, 0);
    @(negedge clk) pwr_dn_n = 1'b1;
    repeat (20) @(negedge clk);
    measure(200);
    chk("R7", "host after wake", r_h, 49, 51);
    chk("R7", "ref after wake", r_r, 24, 26);
  endtask

  task automatic t_test;
    runt_chk = 0;
    @(negedge clk) test_mode = 1'b1;
    exp_wh = TH; exp_wp = 2*TH;
    repeat (40) @(negedge clk);
    runt_chk = 1;
    measure(600);
    chk("R11", "host from test clk", r_h, 99, 101);
    chk("R11", "pci from test clk", r_p, 49, 51);
    chk("R11", "fd from test clk", r_f, 49, 51);
    chk("R11", "kb from test clk", r_k, 24, 26);
    chk("R11", "ref from test clk", r_r, 99, 101);
    runt_chk = 0;
    @(negedge clk) test_mode = 1'b0;
    exp_wh = HH; exp_wp = 2*HH;
    repeat (40) @(negedge clk);
  endtask

  bit done = 0;

  initial begin
    t_reset();
    @(negedge clk) rst_n = 1'b1;
    repeat (20) @(negedge clk);
    t_basic();
    t_host_en();
    t_pci_en();
    t_runt();
    t_sel();
    t_pwr();
    t_test();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule